// File: doc/BRIEF.md
# Synchronous Byte-Write and Select Decoder

This block sits in front of a synchronous burst SRAM core. On each rising clock edge it looks at one active-low enable, one active-high select, one active-low select and the write controls: an active-low write-all input, an active-low lane-gate input and one active-low pick input per lane. From these it registers the cycle type (deselect, read or write) and a write strobe per byte lane. A lane holds 8 data bits plus 1 parity bit. The strobes are also spread into a per-bit write enable that matches the packed data word.

A small state machine holds the registered cycle. It has five states. ST_IDLE is a deselect cycle. ST_RD is a read cycle. ST_WR is a write cycle. ST_DOZE means the sleep input was high at the last edge. ST_WAKE is the forced deselect on the first edge after sleep.

The transitions are as follows:
- From ST_DOZE, the machine stays in ST_DOZE while sleep is high and goes to ST_WAKE when sleep is low.
- From any other state, sleep high leads to ST_DOZE.
- Otherwise, a missing select leads to ST_IDLE.
- Otherwise, any requested lane write leads to ST_WR.
- Otherwise the machine goes to ST_RD.

The data-driver enable is combinational. It follows the output-gate pin and the sleep pin at once, but it can only be high while the registered state is ST_RD. Parameter `ACT_LANES` selects a narrower variant: lanes at or above it never write.

Top module: `sram_sel_wr_decoder`

## Requirements
- R1: A cycle is selected only when enable_n_i=0, sel_a_i=1 and sel_b_n_i=0 at the clock edge. Any other combination gives cyc_o=2'b00 (deselect), no lane strobe and drv_en_o=0.
- R2: On a selected cycle with wr_all_n_i=0, every active lane is written (lane_wr_o has all ACT_LANES low bits set) and cyc_o=2'b10, whatever lane_gate_n_i and lane_pick_n_i are.
- R3: On a selected cycle with wr_all_n_i=1 and lane_gate_n_i=0, lane_wr_o[k] is set exactly when lane_pick_n_i[k]=0 and k<ACT_LANES. Several lanes may be set together. If any bit is set, cyc_o=2'b10.
- R4: On a selected cycle with wr_all_n_i=1 and lane_gate_n_i=1, lane_pick_n_i is ignored: cyc_o=2'b01 (read) and lane_wr_o=0.
- R5: On a selected cycle with wr_all_n_i=1, lane_gate_n_i=0 and no active lane picked, cyc_o=2'b01 and lane_wr_o=0.
- R6: wr_bits_o[8k+7:8k] and wr_bits_o[8*BUS_LANES+k] all equal lane_wr_o[k]. Data bits are low and parity bits are on top.
- R7: drv_en_o=1 only when out_gate_n_i=0, the registered cycle is a read and doze_i=0. It follows out_gate_n_i with no clock. A write cycle always has drv_en_o=0.
- R8: An edge with doze_i=1 gives a deselect cycle. While doze_i=1, drv_en_o=0 immediately.
- R9: The first edge with doze_i=0 after an edge with doze_i=1 gives a deselect cycle, whatever the other inputs are.
- R10: cyc_o and lane_wr_o are registered and show the decode of the inputs at the previous rising edge. Reset (rst_n=0, asynchronous) gives cyc_o=2'b00 and lane_wr_o=0.
- R11: With ACT_LANES=2, lane_wr_o[3:2] stays 0, and a pick of only upper lanes gives a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze_i | input | 1 | Sleep request, active high |
| enable_n_i | input | 1 | Active-low enable |
| sel_a_i | input | 1 | Active-high select |
| sel_b_n_i | input | 1 | Active-low select |
| wr_all_n_i | input | 1 | Active-low write of all lanes |
| lane_gate_n_i | input | 1 | Active-low gate for lane picks |
| lane_pick_n_i | input | BUS_LANES | Active-low per-lane write pick |
| out_gate_n_i | input | 1 | Asynchronous active-low output gate |
| cyc_o | output | 2 | Registered cycle: 00 deselect, 01 read, 10 write |
| lane_wr_o | output | BUS_LANES | Registered per-lane write strobes |
| wr_bits_o | output | BUS_LANES*LANE_W | Per-bit write enable, data bits then parity |
| drv_en_o | output | 1 | Data-driver enable |

## Verification
The bench builds two copies that share every input. One has BUS_LANES=4 and ACT_LANES=4; the other has BUS_LANES=4 and ACT_LANES=2. The full-width copy reaches every pick pattern of the four lanes and the bit layout with parity on top. The narrow copy shows that picks of the upper lanes are dropped, so the same stimulus that writes on one copy reads on the other.

// File: rtl/sdec_pkg.sv
`timescale 1ns/1ps
package sdec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_DOZE = 3'd3,
        ST_WAKE = 3'd4
    } sdec_state_e;

    localparam logic [1:0] CYC_DESEL = 2'b00;
    localparam logic [1:0] CYC_READ  = 2'b01;
    localparam logic [1:0] CYC_WRITE = 2'b10;
endpackage

// File: rtl/sdec_select.sv
`timescale 1ns/1ps
module sdec_select (
    input  logic enable_n_i,
    input  logic sel_a_i,
    input  logic sel_b_n_i,
    output logic sel_o
);
    always_comb begin
        sel_o = !enable_n_i && sel_a_i && !sel_b_n_i;
    end
endmodule

// File: rtl/sdec_lane_write.sv
`timescale 1ns/1ps
module sdec_lane_write #(
    parameter int BUS_LANES = 4,
    parameter int ACT_LANES = 4
) (
    input  logic                 wr_all_n_i,
    input  logic                 lane_gate_n_i,
    input  logic [BUS_LANES-1:0] lane_pick_n_i,
    output logic [BUS_LANES-1:0] lane_req_o
);
    for (genvar k = 0; k < BUS_LANES; k++) begin : g_lane
        if (k < ACT_LANES) begin : g_live
            assign lane_req_o[k] = !wr_all_n_i || (!lane_gate_n_i && !lane_pick_n_i[k]);
        end else begin : g_tied
            assign lane_req_o[k] = 1'b0;
        end
    end
endmodule

// File: rtl/sdec_fsm.sv
`timescale 1ns/1ps
module sdec_fsm
    import sdec_pkg::*;
#(
    parameter int BUS_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 doze_i,
    input  logic                 sel_i,
    input  logic [BUS_LANES-1:0] lane_req_i,
    input  logic                 out_gate_n_i,
    output sdec_state_e          st_o,
    output logic [1:0]           cyc_o,
    output logic [BUS_LANES-1:0] lane_wr_o,
    output logic                 drv_en_o
);
    sdec_state_e          st_q, st_nxt;
    logic [BUS_LANES-1:0] lane_q, lane_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_DOZE: st_nxt = doze_i ? ST_DOZE : ST_WAKE;
            ST_IDLE, ST_RD, ST_WR, ST_WAKE: begin
                if (doze_i)           st_nxt = ST_DOZE;
                else if (!sel_i)      st_nxt = ST_IDLE;
                else if (|lane_req_i) st_nxt = ST_WR;
                else                  st_nxt = ST_RD;
            end
            default: st_nxt = ST_IDLE;
        endcase
        lane_nxt = (st_nxt == ST_WR) ? lane_req_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            lane_q <= '0;
        end else begin
            st_q   <= st_nxt;
            lane_q <= lane_nxt;
        end
    end

    always_comb begin
        cyc_o = CYC_DESEL;
        unique case (st_q)
            ST_RD:   cyc_o = CYC_READ;
            ST_WR:   cyc_o = CYC_WRITE;
            ST_IDLE, ST_DOZE, ST_WAKE: cyc_o = CYC_DESEL;
            default: cyc_o = CYC_DESEL;
        endcase
        lane_wr_o = lane_q;
        drv_en_o  = (st_q == ST_RD) && !out_gate_n_i && !doze_i;
        st_o      = st_q;
    end
endmodule

// File: rtl/sdec_lane_expand.sv
`timescale 1ns/1ps
module sdec_lane_expand #(
    parameter int BUS_LANES = 4,
    parameter int LANE_W    = 9
) (
    input  logic [BUS_LANES-1:0]        lane_wr_i,
    output logic [BUS_LANES*LANE_W-1:0] wr_bits_o
);
    localparam int DBITS = LANE_W - 1;
    localparam int DW    = BUS_LANES * DBITS;

    for (genvar k = 0; k < BUS_LANES; k++) begin : g_exp
        assign wr_bits_o[k*DBITS +: DBITS] = {DBITS{lane_wr_i[k]}};
        assign wr_bits_o[DW + k]           = lane_wr_i[k];
    end
endmodule

// File: rtl/sram_sel_wr_decoder.sv
`timescale 1ns/1ps
module sram_sel_wr_decoder
    import sdec_pkg::*;
#(
    parameter int BUS_LANES = 4,
    parameter int ACT_LANES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        doze_i,
    input  logic                        enable_n_i,
    input  logic                        sel_a_i,
    input  logic                        sel_b_n_i,
    input  logic                        wr_all_n_i,
    input  logic                        lane_gate_n_i,
    input  logic [BUS_LANES-1:0]        lane_pick_n_i,
    input  logic                        out_gate_n_i,
    output logic [1:0]                  cyc_o,
    output logic [BUS_LANES-1:0]        lane_wr_o,
    output logic [BUS_LANES*LANE_W-1:0] wr_bits_o,
    output logic                        drv_en_o
);
    logic                 sel_w;
    logic [BUS_LANES-1:0] lane_req_w;
    sdec_state_e          st_w;

    sdec_select u_select (
        .enable_n_i (enable_n_i),
        .sel_a_i    (sel_a_i),
        .sel_b_n_i  (sel_b_n_i),
        .sel_o      (sel_w)
    );

    sdec_lane_write #(.BUS_LANES(BUS_LANES), .ACT_LANES(ACT_LANES)) u_lane_write (
        .wr_all_n_i    (wr_all_n_i),
        .lane_gate_n_i (lane_gate_n_i),
        .lane_pick_n_i (lane_pick_n_i),
        .lane_req_o    (lane_req_w)
    );

    sdec_fsm #(.BUS_LANES(BUS_LANES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .doze_i       (doze_i),
        .sel_i        (sel_w),
        .lane_req_i   (lane_req_w),
        .out_gate_n_i (out_gate_n_i),
        .st_o         (st_w),
        .cyc_o        (cyc_o),
        .lane_wr_o    (lane_wr_o),
        .drv_en_o     (drv_en_o)
    );

    sdec_lane_expand #(.BUS_LANES(BUS_LANES), .LANE_W(LANE_W)) u_expand (
        .lane_wr_i (lane_wr_o),
        .wr_bits_o (wr_bits_o)
    );
endmodule

// File: rtl/sdec_checker.sv
`timescale 1ns/1ps
module sdec_checker
    import sdec_pkg::*;
#(
    parameter int BUS_LANES = 4,
    parameter int ACT_LANES = 4,
    parameter int LANE_W    = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        doze_i,
    input logic                        sel_w,
    input logic                        wr_all_n_i,
    input logic                        out_gate_n_i,
    input sdec_state_e                 st_w,
    input logic [1:0]                  cyc_o,
    input logic [BUS_LANES-1:0]        lane_wr_o,
    input logic [BUS_LANES*LANE_W-1:0] wr_bits_o,
    input logic                        drv_en_o
);
    localparam int DBITS = LANE_W - 1;
    localparam int DW    = BUS_LANES * DBITS;
    localparam logic [BUS_LANES-1:0] ACT_MASK = BUS_LANES'((2 ** ACT_LANES) - 1);

    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == CYC_WRITE) |-> (lane_wr_o != '0)); // R3
    AST_NONWRITE_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o != CYC_WRITE) |-> (lane_wr_o == '0)); // R1
    AST_DESEL_WHEN_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_w && !doze_i) |=> (cyc_o == CYC_DESEL)); // R1
    AST_ALL_LANES_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_w && !wr_all_n_i && !doze_i && st_w != ST_DOZE) |=> (lane_wr_o == ACT_MASK)); // R2
    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (cyc_o == CYC_READ && !out_gate_n_i)); // R7
    AST_DOZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        doze_i |-> !drv_en_o); // R8
    AST_WAKE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == ST_DOZE && !doze_i) |=> (cyc_o == CYC_DESEL)); // R9

    for (genvar k = 0; k < BUS_LANES; k++) begin : g_chk
        AST_BITS_FOLLOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_bits_o[k*DBITS +: DBITS] == {DBITS{lane_wr_o[k]}})
            && (wr_bits_o[DW + k] == lane_wr_o[k])); // R6
        if (k >= ACT_LANES) begin : g_dead
            AST_UPPER_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !lane_wr_o[k]); // R11
        end
    end
endmodule

bind sram_sel_wr_decoder sdec_checker #(
    .BUS_LANES(BUS_LANES), .ACT_LANES(ACT_LANES), .LANE_W(LANE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .doze_i       (doze_i),
    .sel_w        (sel_w),
    .wr_all_n_i   (wr_all_n_i),
    .out_gate_n_i (out_gate_n_i),
    .st_w         (st_w),
    .cyc_o        (cyc_o),
    .lane_wr_o    (lane_wr_o),
    .wr_bits_o    (wr_bits_o),
    .drv_en_o     (drv_en_o)
);

// File: tb/sram_sel_wr_decoder_bench.sv
`timescale 1ns/1ps
module sram_sel_wr_decoder_bench;
    localparam int BL = 4;
    localparam int LW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic doze = 1'b0, en_n = 1'b1, sa = 1'b0, sb_n = 1'b1;
    logic wa_n = 1'b1, lg_n = 1'b1, og_n = 1'b0;
    logic [BL-1:0] pick_n = '1;

    logic [1:0] cyc4, cyc2;
    logic [BL-1:0] lw4, lw2;
    logic [BL*LW-1:0] wb4, wb2;
    logic drv4, drv2;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit prev_doze = 1'b0;

    typedef struct {
        logic [1:0]    c4, c2;
        logic [BL-1:0] l4, l2;
        logic          d4, d2;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    sram_sel_wr_decoder #(.BUS_LANES(BL), .ACT_LANES(4), .LANE_W(LW)) u_sram_sel_wr_decoder (
        .clk(clk), .rst_n(rst_n), .doze_i(doze), .enable_n_i(en_n), .sel_a_i(sa),
        .sel_b_n_i(sb_n), .wr_all_n_i(wa_n), .lane_gate_n_i(lg_n), .lane_pick_n_i(pick_n),
        .out_gate_n_i(og_n), .cyc_o(cyc4), .lane_wr_o(lw4), .wr_bits_o(wb4), .drv_en_o(drv4));

    sram_sel_wr_decoder #(.BUS_LANES(BL), .ACT_LANES(2), .LANE_W(LW)) u_sram_sel_wr_decoder_two (
        .clk(clk), .rst_n(rst_n), .doze_i(doze), .enable_n_i(en_n), .sel_a_i(sa),
        .sel_b_n_i(sb_n), .wr_all_n_i(wa_n), .lane_gate_n_i(lg_n), .lane_pick_n_i(pick_n),
        .out_gate_n_i(og_n), .cyc_o(cyc2), .lane_wr_o(lw2), .wr_bits_o(wb2), .drv_en_o(drv2));

    function automatic logic [BL*LW-1:0] spread(input logic [BL-1:0] l);
        logic [BL*LW-1:0] b = '0;
        for (int k = 0; k < BL; k++) begin
            b[8*k +: 8]  = {8{l[k]}};
            b[8*BL + k]  = l[k];
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic e_n, input logic a, input logic b_n, input logic w_n,
                         input logic g_n, input logic [BL-1:0] p_n, input logic o_n,
                         input logic dz, input string tag);
        exp_t it;
        logic selected;
        logic [BL-1:0] want;
        @(negedge clk);
        en_n = e_n; sa = a; sb_n = b_n; wa_n = w_n; lg_n = g_n; pick_n = p_n; og_n = o_n; doze = dz;
        selected = !e_n && a && !b_n;
        want = !w_n ? 4'hF : (!g_n ? ~p_n : 4'h0);
        if (dz || prev_doze || !selected) begin
            it.c4 = 2'b00; it.c2 = 2'b00; it.l4 = '0; it.l2 = '0;
        end else begin
            it.l4 = want;
            it.l2 = want & 4'b0011;
            it.c4 = (it.l4 != 0) ? 2'b10 : 2'b01;
            it.c2 = (it.l2 != 0) ? 2'b10 : 2'b01;
        end
        it.d4 = (it.c4 == 2'b01) && !o_n && !dz;
        it.d2 = (it.c2 == 2'b01) && !o_n && !dz;
        it.tag = tag;
        prev_doze = dz;
        sb.push_back(it);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                check(cyc4 == e.c4, e.tag, "cyc(4 lanes)", 64'(cyc4), 64'(e.c4));
                check(lw4 == e.l4, e.tag, "lanes(4 lanes)", 64'(lw4), 64'(e.l4));
                check(wb4 == spread(e.l4), "R6", "bit enables", 64'(wb4), 64'(spread(e.l4)));
                check(drv4 == e.d4, e.tag, "drive(4 lanes)", 64'(drv4), 64'(e.d4));
                check(cyc2 == e.c2, e.tag, "cyc(2 lanes)", 64'(cyc2), 64'(e.c2));
                check(lw2 == e.l2, e.tag, "lanes(2 lanes)", 64'(lw2), 64'(e.l2));
                check(drv2 == e.d2, e.tag, "drive(2 lanes)", 64'(drv2), 64'(e.d2));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check(cyc4 == 2'b00 && lw4 == '0, "R10", "reset state", 64'({cyc4, lw4}), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1: not selected in several ways
        drive(1, 1, 0, 0, 0, 4'h0, 0, 0, "R1");
        drive(0, 0, 0, 0, 0, 4'h0, 0, 0, "R1");
        drive(0, 1, 1, 1, 1, 4'hF, 0, 0, "R1");
        // R2: write-all overrides gate and picks
        drive(0, 1, 0, 0, 1, 4'hF, 0, 0, "R2");
        drive(0, 1, 0, 0, 0, 4'hA, 0, 0, "R2");
        // R10: a deselect right after a write shows on the next edge
        drive(1, 0, 1, 1, 1, 4'hF, 0, 0, "R10");
        // R4: gate high, picks ignored
        drive(0, 1, 0, 1, 1, 4'h0, 0, 0, "R4");
        // R5: gate low, nothing picked
        drive(0, 1, 0, 1, 0, 4'hF, 0, 0, "R5");
        // R3: every pick pattern, R11 covered on the narrow copy
        for (int p = 0; p < 16; p++) drive(0, 1, 0, 1, 0, 4'(p), 0, 0, "R3");
        drive(0, 1, 0, 1, 0, 4'b0011, 0, 0, "R11");
        // R7: read with gate high, then asynchronous toggling
        drive(0, 1, 0, 1, 1, 4'hF, 1, 0, "R7");
        drive(0, 1, 0, 1, 1, 4'hF, 0, 0, "R7");
        @(posedge clk);
        #3;
        og_n = 1'b1;
        #0.2;
        check(drv4 == 1'b0, "R7", "gate high drops drive", 64'(drv4), 64'(0));
        og_n = 1'b0;
        #0.2;
        check(drv4 == 1'b1, "R7", "gate low restores drive", 64'(drv4), 64'(1));
        doze = 1'b1;
        #0.2;
        check(drv4 == 1'b0 && drv2 == 1'b0, "R8", "doze drops drive", 64'({drv4, drv2}), 64'(0));
        doze = 1'b0;
        // R8 and R9: sleep, then forced deselect, then normal
        drive(0, 1, 0, 1, 1, 4'hF, 0, 1, "R8");
        drive(0, 1, 0, 0, 1, 4'hF, 0, 1, "R8");
        drive(0, 1, 0, 0, 1, 4'hF, 0, 0, "R9");
        drive(0, 1, 0, 1, 1, 4'hF, 0, 0, "R9");
        drive(0, 1, 0, 1, 0, 4'hE, 0, 0, "R3");
        drive(1, 0, 1, 1, 1, 4'hF, 0, 0, "R1");
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule